// File: doc/BRIEF.md
# Serial Converter Control-Byte Framer

This block is the digital side of a serial data-converter slave. It runs entirely on the serial clock and has a chip-select input, a serial data input and a serial data output. An active-low chip select alone does nothing. The block waits for a high bit on the data input, collects an eight-bit control byte that begins with that bit, and then starts a conversion. After one busy cycle it shifts a twelve-bit result out MSB first, and after the result it sends zeros. The conversion value comes in on a parallel port, and the control byte goes out on a parallel port with a one-cycle strobe so that surrounding logic can decode its channel and mode fields.

A new start bit may arrive while the previous result is still leaving the output. This lets a host run conversions back to back every 15 serial clocks, or every 16 clocks when it works in whole bytes. A start bit that comes too early is ignored. Raising chip select tri-states the output, cancels any conversion in flight and returns the framer to start-bit hunting.

Top module: `sar_serial_framer`

## Requirements
- R1: After reset `sstrb_o` is 1, `dout_o` is 0 and `ctrl_valid_o` is 0. `dout_o` stays 0 until the first conversion has started.
- R2: Chip select going low with the data input held at 0 starts no framing, and `ctrl_valid_o` stays 0.
- R3: The data input is sampled on rising clock edges. With chip select low and the framer idle, the first sampled 1 is the start bit and becomes `ctrl_o[7]`. The next seven sampled bits fill `ctrl_o[6]` down to `ctrl_o[0]` in arrival order. `ctrl_valid_o` is high for exactly the one cycle after the rising edge that samples the eighth bit.
- R4: The conversion starts on the falling edge after the eighth control bit. `result_i` is captured on that edge. For that one busy cycle `dout_o` is 0 and `sstrb_o` is 0. `sstrb_o` is 1 in every other cycle.
- R5: `dout_o` changes on falling edges. On the falling edges after the busy cycle it shows result bits 11 down to 0, and after bit 0 it shows 0.
- R6: A 1 on the data input at any of the seven rising edges after the eighth control bit is ignored, because result bit 5 has not yet reached `dout_o`.
- R7: A start bit sampled 15 rising edges after the previous start bit is accepted. Its new conversion runs correctly, and the previous result finishes intact before it.
- R8: A start bit sampled 16 rising edges after the previous start bit also yields a correct second control byte and result.
- R9: While chip select is high, `dout_oe_o` is 0, the framer is idle and the output shifter is cleared. A start bit after chip select returns low begins a new control byte and conversion, and the one in flight is abandoned.
- R10: After 16 consecutive 0 bits with chip select low, the framer is hunting for a start bit, whatever state it was in before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; input sampled on rise, output driven on fall |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial control input |
| result_i | input | 12 | Parallel conversion value, captured when a conversion starts |
| dout_o | output | 1 | Serial result output |
| dout_oe_o | output | 1 | Output enable for `dout_o`, low while deselected |
| sstrb_o | output | 1 | Status strobe, low during the busy cycle |
| ctrl_o | output | 8 | Last complete control byte, start bit in bit 7 |
| ctrl_valid_o | output | 1 | One-cycle strobe for a new `ctrl_o` |

## Verification
The hardest state to reach is an overlap. Here a second control byte is being gathered on the input while the tail of the earlier result is still on the output, and `result_i` has to change between the two capture edges without disturbing either. The directed sequences place the second start bit exactly 15 and 16 edges after the first and change `result_i` only after the first capture. They also place a 1 on the input just before the acceptance window opens, and they drop chip select in the middle of a result, so that the window's edge and the abort path are both exercised.

// File: rtl/sar_framer_pkg.sv
package sar_framer_pkg;
  typedef enum logic [1:0] {
    HUNT_IDLE = 2'd0,
    HUNT_CTRL = 2'd1,
    HUNT_BUSY = 2'd2
  } hunt_state_e;
endpackage

// File: rtl/sar_framer_hunt.sv
module sar_framer_hunt
  import sar_framer_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int RES_W    = 12,
  parameter int OPEN_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              din_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ctrl_valid_o
);
  // rising edges after the control byte during which din is ignored
  localparam int IGN   = RES_W - OPEN_BIT;
  localparam int CMAX  = (CTRL_W > IGN) ? CTRL_W : IGN;
  localparam int CNT_W = $clog2(CMAX + 1);

  hunt_state_e         state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CTRL_W-2:0]   sh_q;
  logic [CTRL_W-1:0]   ctrl_q;
  logic                valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HUNT_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ctrl_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (csn_i) begin
        state_q <= HUNT_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          HUNT_IDLE: begin
            if (din_i) begin
              state_q <= HUNT_CTRL;
              sh_q    <= (CTRL_W-1)'(1);
              cnt_q   <= CNT_W'(1);
            end
          end
          HUNT_CTRL: begin
            sh_q <= {sh_q[CTRL_W-3:0], din_i};
            if (cnt_q == CNT_W'(CTRL_W - 1)) begin
              ctrl_q  <= {sh_q, din_i};
              valid_q <= 1'b1;
              state_q <= HUNT_BUSY;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          HUNT_BUSY: begin
            // reopen hunting once the open bit has left on dout
            if (cnt_q == CNT_W'(IGN - 1)) begin
              state_q <= HUNT_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: begin
            state_q <= HUNT_IDLE;
            cnt_q   <= '0;
          end
        endcase
      end
    end
  end

  assign ctrl_o       = ctrl_q;
  assign ctrl_valid_o = valid_q;
endmodule

// File: rtl/sar_framer_shift.sv
module sar_framer_shift #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csn_i,
  input  logic             load_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o,
  output logic             sstrb_o
);
  // extra MSB carries the busy-cycle zero
  logic [RES_W:0] sh_q;
  logic           sstrb_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      sstrb_q <= 1'b1;
    end else if (csn_i) begin
      sh_q    <= '0;
      sstrb_q <= 1'b1;
    end else if (load_i) begin
      sh_q    <= {1'b0, result_i};
      sstrb_q <= 1'b0;
    end else begin
      sh_q    <= {sh_q[RES_W-1:0], 1'b0};
      sstrb_q <= 1'b1;
    end
  end

  assign dout_o  = sh_q[RES_W];
  assign sstrb_o = sstrb_q;
endmodule

// File: rtl/sar_serial_framer.sv
module sar_serial_framer #(
  parameter int CTRL_W   = 8,
  parameter int RES_W    = 12,
  parameter int OPEN_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              din_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              sstrb_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ctrl_valid_o
);
  logic conv_go;

  sar_framer_hunt #(
    .CTRL_W  (CTRL_W),
    .RES_W   (RES_W),
    .OPEN_BIT(OPEN_BIT)
  ) u_hunt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csn_i       (csn_i),
    .din_i       (din_i),
    .ctrl_o      (ctrl_o),
    .ctrl_valid_o(conv_go)
  );

  sar_framer_shift #(
    .RES_W(RES_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .csn_i   (csn_i),
    .load_i  (conv_go),
    .result_i(result_i),
    .dout_o  (dout_o),
    .sstrb_o (sstrb_o)
  );

  assign ctrl_valid_o = conv_go;
  assign dout_oe_o    = ~csn_i;
endmodule

// File: rtl/sar_serial_framer_chk.sv
module sar_serial_framer_chk #(
  parameter int MIN_GAP = 15
) (
  input logic clk_i,
  input logic rst_ni,
  input logic csn_i,
  input logic dout_o,
  input logic dout_oe_o,
  input logic sstrb_o,
  input logic ctrl_msb_i,
  input logic ctrl_valid_o
);
  localparam int GW = $clog2(MIN_GAP + 1) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      seen_q  <= 1'b0;
      abort_q <= 1'b0;
    end else if (ctrl_valid_o) begin
      gap_q   <= GW'(1);
      seen_q  <= 1'b1;
      abort_q <= 1'b0;
    end else begin
      if (gap_q != '1) gap_q <= gap_q + GW'(1);
      if (csn_i) abort_q <= 1'b1;
    end
  end

  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !dout_o);
  p_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_o |=> !ctrl_valid_o);
  p_start_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_o |-> ctrl_msb_i);
  p_busy_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sstrb_o |-> !dout_o);
  p_busy_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sstrb_o |=> sstrb_o);
  p_min_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_valid_o && seen_q && !abort_q) |-> (gap_q >= GW'(MIN_GAP)));
  p_deselect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_oe_o |=> !ctrl_valid_o);
endmodule

bind sar_serial_framer sar_serial_framer_chk #(
  .MIN_GAP(CTRL_W + RES_W - OPEN_BIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csn_i       (csn_i),
  .dout_o      (dout_o),
  .dout_oe_o   (dout_oe_o),
  .sstrb_o     (sstrb_o),
  .ctrl_msb_i  (ctrl_o[CTRL_W-1]),
  .ctrl_valid_o(ctrl_valid_o)
);

// File: tb/sar_serial_framer_tb.sv
module sar_serial_framer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csn = 1'b1;
  logic        din = 1'b0;
  logic [11:0] result = '0;
  logic        dout, dout_oe, sstrb, cvalid;
  logic [7:0]  ctrl;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [63:0] seq_din, seq_csn;
  logic [63:0] rec_dout, rec_valid, rec_sstrb, rec_oe;
  logic [7:0]  rec_ctrl [64];
  logic [11:0] res_b;
  int          sw_step;

  always #2 clk = ~clk;

  sar_serial_framer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .csn_i       (csn),
    .din_i       (din),
    .result_i    (result),
    .dout_o      (dout),
    .dout_oe_o   (dout_oe),
    .sstrb_o     (sstrb),
    .ctrl_o      (ctrl),
    .ctrl_valid_o(cvalid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_seq(input logic [11:0] ra);
    seq_din = '0;
    seq_csn = '0;
    result  = ra;
    res_b   = ra;
    sw_step = 0;
  endtask

  task automatic put_byte(input int at, input logic [7:0] b);
    for (int i = 0; i < 8; i++) seq_din[at+i] = b[7-i];
  endtask

  // one deselect step, then steps 1..len; sample at rise+1 (dout shows previous fall)
  task automatic run_seq(input int len);
    csn = 1'b1; din = 1'b0;
    @(posedge clk); #1;
    for (int n = 1; n <= len; n++) begin
      csn = seq_csn[n];
      din = seq_din[n];
      if (n == sw_step) result = res_b;
      @(posedge clk); #1;
      rec_dout[n]  = dout;
      rec_valid[n] = cvalid;
      rec_sstrb[n] = sstrb;
      rec_oe[n]    = dout_oe;
      rec_ctrl[n]  = ctrl;
    end
  endtask

  task automatic chk_result(input string tag, input int first, input logic [11:0] v);
    for (int j = 0; j < 12; j++) chk(tag, int'(rec_dout[first+j]), int'(v[11-j]));
  endtask

  function automatic int count_valid(input int from, input int to);
    int c = 0;
    for (int n = from; n <= to; n++) if (rec_valid[n]) c++;
    return c;
  endfunction

  task automatic t_reset();
    chk("R1 sstrb after reset", int'(sstrb), 1);
    chk("R1 dout after reset", int'(dout), 0);
    chk("R1 valid after reset", int'(cvalid), 0);
  endtask

  task automatic t_cs_only();
    int ones = 0;
    clear_seq(12'hFFF);
    run_seq(24);
    for (int n = 1; n <= 24; n++) if (rec_dout[n]) ones++;
    chk("R2 no framing on zeros", count_valid(1, 24), 0);
    chk("R1 dout zero before first conversion", ones, 0);
  endtask

  task automatic t_single();
    clear_seq(12'hA5C);
    put_byte(1, 8'h96);
    run_seq(30);
    chk("R3 valid after eighth bit", int'(rec_valid[8]), 1);
    chk("R3 single valid", count_valid(1, 30), 1);
    chk("R3 control byte", int'(rec_ctrl[8]), 8'h96);
    chk("R4 sstrb before busy", int'(rec_sstrb[8]), 1);
    chk("R4 sstrb busy low", int'(rec_sstrb[9]), 0);
    chk("R4 sstrb after busy", int'(rec_sstrb[10]), 1);
    chk("R4 dout busy zero", int'(rec_dout[9]), 0);
    chk_result("R5 result bits", 10, 12'hA5C);
    for (int n = 22; n <= 30; n++) chk("R5 zero padding", int'(rec_dout[n]), 0);
  endtask

  task automatic t_early();
    clear_seq(12'h3C5);
    put_byte(1, 8'hC3);
    for (int n = 9; n <= 15; n++) seq_din[n] = 1'b1;
    run_seq(40);
    chk("R6 early ones ignored", count_valid(9, 40), 0);
    chk("R6 first byte", int'(rec_ctrl[8]), 8'hC3);
    chk_result("R6 result intact", 10, 12'h3C5);
  endtask

  task automatic t_pipe(input string tag, input int gap, input logic [7:0] ca,
                        input logic [7:0] cb, input logic [11:0] ra, input logic [11:0] rb);
    clear_seq(ra);
    put_byte(1, ca);
    put_byte(1 + gap, cb);
    res_b   = rb;
    sw_step = 10;
    run_seq(50);
    chk({tag, " first valid"}, int'(rec_valid[8]), 1);
    chk({tag, " second valid"}, int'(rec_valid[8+gap]), 1);
    chk({tag, " valid count"}, count_valid(1, 50), 2);
    chk({tag, " first byte"}, int'(rec_ctrl[8]), int'(ca));
    chk({tag, " second byte"}, int'(rec_ctrl[8+gap]), int'(cb));
    chk_result({tag, " first result"}, 10, ra);
    chk({tag, " second busy"}, int'(rec_sstrb[9+gap]), 0);
    chk_result({tag, " second result"}, 10 + gap, rb);
    chk({tag, " tail zero"}, int'(rec_dout[22+gap]), 0);
  endtask

  task automatic t_abort();
    clear_seq(12'hFFF);
    put_byte(1, 8'hE0);
    seq_csn[13] = 1'b1;
    put_byte(14, 8'h9D);
    res_b   = 12'h0F1;
    sw_step = 14;
    run_seq(40);
    chk("R9 dout before abort", int'(rec_dout[12]), 1);
    chk("R9 oe selected", int'(rec_oe[12]), 1);
    chk("R9 oe deselected", int'(rec_oe[13]), 0);
    chk("R9 shifter cleared", int'(rec_dout[13]), 0);
    chk("R9 cleared stays zero", int'(rec_dout[14]), 0);
    chk("R9 new valid", int'(rec_valid[21]), 1);
    chk("R9 new byte", int'(rec_ctrl[21]), 8'h9D);
    chk("R9 valid count", count_valid(1, 40), 2);
    chk_result("R9 new result", 23, 12'h0F1);
  endtask

  task automatic t_flush();
    clear_seq(12'h6B2);
    seq_din[1] = 1'b1;
    seq_din[3] = 1'b1;
    put_byte(20, 8'hA7);
    run_seq(45);
    chk("R10 partial byte padded", int'(rec_ctrl[8]), 8'hA0);
    chk("R10 start after zeros", int'(rec_valid[27]), 1);
    chk("R10 byte after zeros", int'(rec_ctrl[27]), 8'hA7);
    chk("R10 valid count", count_valid(9, 45), 1);
    chk_result("R10 result after zeros", 29, 12'h6B2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_cs_only();
    t_single();
    t_early();
    t_pipe("R7 15-cycle", 15, 8'h8F, 8'hB1, 12'h123, 12'hEDC);
    t_pipe("R8 16-cycle", 16, 8'hF2, 8'h84, 12'h9A7, 12'h5A6);
    t_abort();
    t_flush();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule